// File: doc/BRIEF.md
# Sharing-Aware Shared Victim Cache

This block is a last-level cache shared by four cores. It is filled only by lines that the cores' private second-level caches evict. A victim enters through the insert port with its line address, its data and the number of the core that evicted it. If the set already holds that address, the way is rewritten in place. Otherwise a way is chosen with a not-recently-used scheme: the lowest-numbered empty way if there is one, and otherwise the lowest-numbered way whose reference bit is clear. A lookup that misses allocates nothing.

Any core may look up any line. A lookup carries a line address, the requesting core and a kind bit that says whether it is an instruction fetch or a data load. The response comes one cycle later as a hit flag and the line data. An instruction-fetch hit always leaves the line in the cache. A data-load hit leaves the line only if the line was already marked as shared before the request. Otherwise the line is invalidated as it is returned, so unshared data moves out exclusively to the requester.

A line becomes shared when a lookup or a re-insert of it comes from a core other than its recorded owner. The mark then stays until the line leaves the cache. When an insert and a lookup fall on the same set in the same cycle, the lookup is answered from the contents before the insert, and the insert then applies on top of the lookup's effects.

Top module: `share_victim_cache`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and `rsp_hit` is never high without `rsp_valid`.
- R2: A lookup that misses allocates no line: a repeated lookup of the same address still misses, and without an insert the number of resident lines never grows.
- R3: A line inserted on behalf of one core hits on a lookup from any other core.
- R4: The set is chosen by the low log2(NUM_SETS) bits of the line address. Each set holds NUM_WAYS (32) lines, all of which stay resident until a 33rd distinct victim arrives.
- R5: An insert that matches no resident line uses the lowest-numbered invalid way. In a full set it uses the lowest-numbered way whose reference bit is clear. A hit that keeps its line, and every insert, sets that way's reference bit. If the set's bits then become all ones, every bit except that way's is cleared.
- R6: An instruction-fetch hit (`lk_is_code` = 1) returns the line data and leaves the line valid.
- R7: A data-load hit (`lk_is_code` = 0) on a line not marked shared before the request returns the data and invalidates the line. This holds even when the requester is a different core.
- R8: A line is marked shared by a kept lookup hit, or by a re-insert, from a core other than its recorded owner. Data-load hits on a shared line keep it, and the mark survives those hits.
- R9: Inserting an address that is already resident overwrites that way's data and owner and never leaves a second copy.
- R10: An insert and a lookup to the same set in the same cycle: the lookup sees only the old contents, and the insert is applied after the lookup's own invalidation or update.
- R11: A synchronous active-high `rst` empties the cache: every lookup after reset misses.
- R12: A missing lookup returns `rsp_data` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Victim insert request |
| in_addr | input | ADDR_W | Line address of the victim |
| in_core | input | log2(NUM_CORES) | Core that evicted the victim |
| in_data | input | DATA_W | Victim line data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Line address looked up |
| lk_core | input | log2(NUM_CORES) | Requesting core |
| lk_is_code | input | 1 | 1 = instruction fetch, 0 = data load |
| rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | DATA_W | Line data on a hit, zero on a miss |

## Verification
The hardest state to reach is a full set in which the reference bits have been reset by the all-ones rule and then selectively set again. Only that state shows which way the replacement scheme evicts. The stimulus fills one set with 32 distinct victims in ascending way order, so the last insert clears every bit except its own. It then adds one new victim, touches a chosen line with an instruction-fetch hit, and inserts another victim. Probing each address afterwards shows exactly which two lines were displaced. The same-cycle case is reached by issuing an insert and a lookup of the same address together: first on a fresh line, then on an unshared line that the data lookup is invalidating at that moment.

// File: rtl/svc_pkg.sv
package svc_pkg;
    typedef enum logic {
        REQ_DATA = 1'b0,
        REQ_CODE = 1'b1
    } req_kind_e;
endpackage

// File: rtl/svc_first_set.sv
// Lowest-index set bit finder.
module svc_first_set #(
    parameter int WIDTH = 32,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/svc_tag_match.sv
// Parallel tag compare across the ways of one set.
module svc_tag_match #(
    parameter int NUM_WAYS = 32,
    parameter int TAG_W    = 14,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [NUM_WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]               tag,
    output logic                           hit,
    output logic [WAY_W-1:0]               way
);
    logic [NUM_WAYS-1:0] eq;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign eq[w] = valid[w] && (tags[w] == tag);
    end

    svc_first_set #(.WIDTH(NUM_WAYS)) u_enc (
        .bits (eq),
        .found(hit),
        .idx  (way)
    );
endmodule

// File: rtl/svc_victim_pick.sv
// Replacement choice: empty way first, otherwise lowest way with clear reference bit.
module svc_victim_pick #(
    parameter int NUM_WAYS = 32,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0] valid,
    input  logic [NUM_WAYS-1:0] refb,
    output logic [WAY_W-1:0]    way
);
    logic             any_free;
    logic             any_cold;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] cold_way;

    svc_first_set #(.WIDTH(NUM_WAYS)) u_free (
        .bits (~valid),
        .found(any_free),
        .idx  (free_way)
    );

    svc_first_set #(.WIDTH(NUM_WAYS)) u_cold (
        .bits (~refb),
        .found(any_cold),
        .idx  (cold_way)
    );

    always_comb begin
        if (any_free) begin
            way = free_way;
        end else if (any_cold) begin
            way = cold_way;
        end else begin
            way = '0;
        end
    end
endmodule

// File: rtl/share_victim_cache.sv
module share_victim_cache
    import svc_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 32,
    parameter int NUM_SETS  = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 64,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int TAG_W    = ADDR_W - SET_W,
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CORE_W-1:0] in_core,
    input  logic [DATA_W-1:0] in_data,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [CORE_W-1:0] lk_core,
    input  logic              lk_is_code,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic [NUM_WAYS-1:0]             valid;
        logic [NUM_WAYS-1:0]             refb;
        logic [NUM_WAYS-1:0]             shared;
        logic [NUM_WAYS-1:0][CORE_W-1:0] owner;
        logic [NUM_WAYS-1:0][TAG_W-1:0]  tag;
        logic [NUM_WAYS-1:0][DATA_W-1:0] data;
    } set_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [DATA_W-1:0] data;
    } rsp_t;

    set_t sets_q [NUM_SETS];
    set_t sets_d [NUM_SETS];
    rsp_t rsp_q, rsp_d;

    // Address split
    logic [SET_W-1:0] lk_set, in_set;
    logic [TAG_W-1:0] lk_tag, in_tag;
    assign lk_set = lk_addr[SET_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:SET_W];
    assign in_set = in_addr[SET_W-1:0];
    assign in_tag = in_addr[ADDR_W-1:SET_W];

    // Set the touched way's reference bit; when all become set, keep only that one.
    function automatic logic [NUM_WAYS-1:0] touch_ref(
        input logic [NUM_WAYS-1:0] r,
        input logic [WAY_W-1:0]    w
    );
        logic [NUM_WAYS-1:0] n;
        n    = r;
        n[w] = 1'b1;
        if (&n) begin
            n    = '0;
            n[w] = 1'b1;
        end
        return n;
    endfunction

    // Lookup path: compare against the stored contents
    set_t             lk_row;
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;
    assign lk_row = sets_q[lk_set];

    svc_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_lk_match (
        .tags (lk_row.tag),
        .valid(lk_row.valid),
        .tag  (lk_tag),
        .hit  (lk_hit),
        .way  (lk_way)
    );

    // Row after the lookup's own effect, and the base row the insert builds on
    set_t lk_after;
    set_t in_base;
    logic lk_drops;

    always_comb begin
        lk_after = lk_row;
        lk_drops = 1'b0;
        if (lk_valid && lk_hit) begin
            if ((lk_is_code == REQ_DATA) && !lk_row.shared[lk_way]) begin
                lk_drops                = 1'b1;
                lk_after.valid[lk_way]  = 1'b0;
            end else begin
                lk_after.refb = touch_ref(lk_row.refb, lk_way);
                if (lk_core != lk_row.owner[lk_way]) begin
                    lk_after.shared[lk_way] = 1'b1;
                end
            end
        end
        if (lk_valid && (in_set == lk_set)) begin
            in_base = lk_after;
        end else begin
            in_base = sets_q[in_set];
        end
    end

    // Insert path: match and replacement against the post-lookup row
    logic             in_hit;
    logic [WAY_W-1:0] in_hit_way;
    logic [WAY_W-1:0] in_vic_way;

    svc_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_in_match (
        .tags (in_base.tag),
        .valid(in_base.valid),
        .tag  (in_tag),
        .hit  (in_hit),
        .way  (in_hit_way)
    );

    svc_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .valid(in_base.valid),
        .refb (in_base.refb),
        .way  (in_vic_way)
    );

    // Next-state computation
    always_comb begin
        set_t row;
        for (int s = 0; s < NUM_SETS; s++) begin
            sets_d[s] = sets_q[s];
        end

        rsp_d.valid = lk_valid;
        rsp_d.hit   = lk_valid && lk_hit;
        rsp_d.data  = (lk_valid && lk_hit) ? lk_row.data[lk_way] : '0;

        if (lk_valid) begin
            sets_d[lk_set] = lk_after;
        end

        row = in_base;
        if (in_hit) begin
            row.data[in_hit_way] = in_data;
            if (in_core != in_base.owner[in_hit_way]) begin
                row.shared[in_hit_way] = 1'b1;
            end
            row.owner[in_hit_way] = in_core;
            row.refb              = touch_ref(in_base.refb, in_hit_way);
        end else begin
            row.valid[in_vic_way]  = 1'b1;
            row.tag[in_vic_way]    = in_tag;
            row.data[in_vic_way]   = in_data;
            row.owner[in_vic_way]  = in_core;
            row.shared[in_vic_way] = 1'b0;
            row.refb               = touch_ref(in_base.refb, in_vic_way);
        end
        if (in_valid) begin
            sets_d[in_set] = row;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                sets_q[s] <= '0;
            end
            rsp_q <= '0;
        end else begin
            for (int s = 0; s < NUM_SETS; s++) begin
                sets_q[s] <= sets_d[s];
            end
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_data  = rsp_q.data;

    // Occupancy view for the checks below
    logic [NUM_SETS*NUM_WAYS-1:0] all_valid;
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_flat
        assign all_valid[s*NUM_WAYS +: NUM_WAYS] = sets_q[s].valid;
    end

    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    p_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);
    p_hit_in_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);
    p_no_alloc_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($countones(all_valid) <= $past($countones(all_valid))));
    p_code_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_is_code && lk_hit && !in_valid)
        |=> ($countones(all_valid) == $past($countones(all_valid))));
    p_data_drops_r7: assert property (@(posedge clk) disable iff (rst)
        (lk_drops && !in_valid)
        |=> ($countones(all_valid) == $past($countones(all_valid)) - 1));
    p_miss_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0));
endmodule

// File: tb/share_victim_cache_test.sv
module share_victim_cache_test;
    localparam int CW = 2;
    localparam int AW = 16;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [AW-1:0] in_addr;
    logic [CW-1:0] in_core;
    logic [DW-1:0] in_data;
    logic          lk_valid;
    logic [AW-1:0] lk_addr;
    logic [CW-1:0] lk_core;
    logic          lk_is_code;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [DW-1:0] rsp_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    share_victim_cache uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_addr(in_addr), .in_core(in_core), .in_data(in_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_core(lk_core), .lk_is_code(lk_is_code),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
    );

    function automatic logic [AW-1:0] mk(input int tag, input int set);
        return {14'(tag), 2'(set)};
    endfunction

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [7:0] salt);
        return {salt, 8'h5A, a, ~a, a ^ 16'h1234};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic insert(input logic [AW-1:0] a, input int c, input logic [DW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_core = CW'(c); in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Lookup and compare hit and data against expectation.
    task automatic probe(input string req, input logic [AW-1:0] a, input int c, input logic code,
                         input logic exp_hit, input logic [DW-1:0] exp_data);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_core = CW'(c); lk_is_code = code;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, {63'd0, rsp_hit}, {63'd0, exp_hit});
        chk(req, rsp_data, exp_hit ? exp_data : '0);
    endtask

    task automatic t_reset_r11;
        insert(mk(7, 0), 0, pat(mk(7, 0), 8'h01));
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R11 rsp_valid after reset", {63'd0, rsp_valid}, '0);
        probe("R11 miss after reset", mk(7, 0), 0, 1'b1, 1'b0, '0);
    endtask

    task automatic t_latency_r1;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = mk(99, 0); lk_core = 0; lk_is_code = 1'b1;
        chk("R1 no response in request cycle", {63'd0, rsp_valid}, '0);
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R1 response one cycle later", {63'd0, rsp_valid}, 64'd1);
        @(negedge clk);
        chk("R1 response lasts one cycle", {63'd0, rsp_valid}, '0);
    endtask

    task automatic t_no_alloc_r2;
        probe("R2 first miss R12", mk(50, 0), 1, 1'b0, 1'b0, '0);
        probe("R2 repeated miss", mk(50, 0), 1, 1'b1, 1'b0, '0);
    endtask

    task automatic t_cross_core_code_r3_r6;
        logic [AW-1:0] a;
        a = mk(3, 2);
        insert(a, 0, pat(a, 8'h10));
        probe("R3 other core hits", a, 2, 1'b1, 1'b1, pat(a, 8'h10));
        probe("R6 code hit keeps line", a, 3, 1'b1, 1'b1, pat(a, 8'h10));
    endtask

    task automatic t_data_exclusive_r7;
        logic [AW-1:0] a;
        a = mk(4, 2);
        insert(a, 0, pat(a, 8'h20));
        probe("R7 data hit from other core returns data", a, 1, 1'b0, 1'b1, pat(a, 8'h20));
        probe("R7 line invalidated after data hit", a, 0, 1'b1, 1'b0, '0);
    endtask

    task automatic t_shared_lookup_r8;
        logic [AW-1:0] a;
        a = mk(5, 3);
        insert(a, 0, pat(a, 8'h30));
        probe("R8 code lookup by other core", a, 1, 1'b1, 1'b1, pat(a, 8'h30));
        probe("R8 data hit on shared keeps", a, 0, 1'b0, 1'b1, pat(a, 8'h30));
        probe("R8 shared mark persists", a, 3, 1'b0, 1'b1, pat(a, 8'h30));
        probe("R8 still resident", a, 2, 1'b0, 1'b1, pat(a, 8'h30));
    endtask

    task automatic t_shared_reinsert_r8_r9;
        logic [AW-1:0] a, b;
        a = mk(6, 3);
        insert(a, 0, pat(a, 8'h40));
        insert(a, 2, pat(a, 8'h41));
        probe("R8 reinsert by other core shares, R9 new data", a, 2, 1'b0, 1'b1, pat(a, 8'h41));
        probe("R8 kept after data hit", a, 2, 1'b0, 1'b1, pat(a, 8'h41));
        b = mk(8, 3);
        insert(b, 1, pat(b, 8'h50));
        insert(b, 1, pat(b, 8'h51));
        probe("R9 overwrite by same core", b, 1, 1'b0, 1'b1, pat(b, 8'h51));
        probe("R9 no stale duplicate", b, 1, 1'b1, 1'b0, '0);
    endtask

    task automatic t_same_cycle_r10;
        logic [AW-1:0] a;
        a = mk(9, 2);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_core = 0; in_data = pat(a, 8'h60);
        lk_valid = 1'b1; lk_addr = a; lk_core = 1; lk_is_code = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; lk_valid = 1'b0;
        chk("R10 lookup sees old contents", {63'd0, rsp_hit}, '0);
        probe("R10 insert applied", a, 1, 1'b1, 1'b1, pat(a, 8'h60));
        a = mk(10, 2);
        insert(a, 0, pat(a, 8'h70));
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_core = 0; in_data = pat(a, 8'h71);
        lk_valid = 1'b1; lk_addr = a; lk_core = 0; lk_is_code = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; lk_valid = 1'b0;
        chk("R10 data lookup gets old data", rsp_data, pat(a, 8'h70));
        probe("R10 insert after invalidation", a, 0, 1'b1, 1'b1, pat(a, 8'h71));
    endtask

    task automatic t_replace_r4_r5;
        for (int t = 0; t < 32; t++) insert(mk(100 + t, 1), t % 4, pat(mk(100 + t, 1), 8'h80));
        probe("R4 way 0 resident", mk(100, 1), 0, 1'b1, 1'b1, pat(mk(100, 1), 8'h80));
        probe("R4 way 31 resident", mk(131, 1), 0, 1'b1, 1'b1, pat(mk(131, 1), 8'h80));
        // Both probes touched refs of ways 0 and 31; refill order makes way 1 next cold.
        insert(mk(132, 1), 0, pat(mk(132, 1), 8'h81));   // evicts way 1
        probe("R5 touch way 2", mk(102, 1), 0, 1'b1, 1'b1, pat(mk(102, 1), 8'h80));
        insert(mk(133, 1), 0, pat(mk(133, 1), 8'h82));   // evicts way 3
        probe("R5 lowest cold evicted", mk(101, 1), 0, 1'b1, 1'b0, '0);
        probe("R5 touched line kept", mk(102, 1), 0, 1'b1, 1'b1, pat(mk(102, 1), 8'h80));
        probe("R5 next cold evicted", mk(103, 1), 0, 1'b1, 1'b0, '0);
        probe("R5 way 0 kept", mk(100, 1), 0, 1'b1, 1'b1, pat(mk(100, 1), 8'h80));
        probe("R5 way 4 kept", mk(104, 1), 0, 1'b1, 1'b1, pat(mk(104, 1), 8'h80));
        probe("R5 new victim resident", mk(132, 1), 0, 1'b1, 1'b1, pat(mk(132, 1), 8'h81));
        probe("R5 second victim resident", mk(133, 1), 0, 1'b1, 1'b1, pat(mk(133, 1), 8'h82));
        probe("R4 other set unaffected", mk(3, 2), 0, 1'b1, 1'b1, pat(mk(3, 2), 8'h10));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_addr = '0; in_core = '0; in_data = '0;
        lk_valid = 1'b0; lk_addr = '0; lk_core = '0; lk_is_code = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_r11();
        t_latency_r1();
        t_no_alloc_r2();
        t_cross_core_code_r3_r6();
        t_data_exclusive_r7();
        t_shared_lookup_r8();
        t_shared_reinsert_r8_r9();
        t_same_cycle_r10();
        t_replace_r4_r5();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule